// File: doc/BRIEF.md
# Pre-trigger capture window controller

This block steers a circular sample memory for a logic analyser. When a start command arrives it writes every valid sample to consecutive addresses, wrapping at the configured memory depth. A trigger is not armed until a pre-trigger window of samples has been written. Once armed, the first sample that arrives with the trigger hit is accepted. The controller then counts post-trigger samples until the window plus the post-trigger part equals the requested total, and then it stops writing.

When the trigger is accepted, the block produces a one-cycle record. The record holds the sample index of the trigger, the memory address where readout must begin (the oldest sample of the pre-trigger window) and the number of samples from the trigger onward. Because the record is produced at the trigger, it always comes before the capture completes and before any readout. The pre-trigger request is quantised and bounded before use. The bounds depend on the memory depth and on whether the capture is buffered or streaming.

The controller has five states. `ST_IDLE` waits for a start. `ST_FILL` writes the window before the trigger can arm. `ST_ARMED` keeps writing and waits for a hit. `ST_POST` writes the samples after the trigger. `ST_DONE` holds the finished capture. The transitions are as follows:
- Start moves `ST_IDLE` or `ST_DONE` to `ST_FILL`.
- The last window sample moves `ST_FILL` to `ST_ARMED`.
- An accepted hit moves `ST_ARMED` to `ST_POST`, or straight to `ST_DONE` when only one post-trigger sample is due.
- The final sample moves `ST_POST` to `ST_DONE`.
- Stop moves any state to `ST_IDLE`.

Top module: `capture_window_ctrl`

## Requirements
- R1: The effective pre-trigger window is the request raised to at least 64 samples and then rounded down to a multiple of 64.
- R2: Before rounding, the window is limited to floor(depth*90/100) samples when `stream_mode` is 0, and to floor(depth*10/100) samples when it is 1.
- R3: The requested total is `sample_count`*16 samples. The capture ends on the cycle in which window plus post-trigger writes (the trigger sample counted as post-trigger) reach that total. That write still happens, `done` is high from the next cycle, and no write happens while `done` is high.
- R4: After a start, valid samples are written to addresses 0, 1, 2 and so on, and the address wraps to 0 after depth-1. `wr_en` equals `sample_valid` while capturing.
- R5: A trigger hit is ignored until the full window has been written. It is accepted on the first valid sample that carries it after that point.
- R6: One cycle after the accepting edge, `rec_valid` pulses for one cycle. With it, `rec_trig_pos` is the index of the accepted sample counted from 0 at start, `rec_start_addr` is (trigger address - window) mod depth, and `rec_remain` is total - window.
- R7: A command with bit 7 of `cmd_flags` set is a stop. It forces `wr_en` low in the same cycle, and the block returns to idle: no further writes, no record, `done` low.
- R8: A command with bit 7 clear is a start. It is taken only in idle or done, and it restarts the address and index at 0 and clears `done`. A start during a capture is ignored.
- R9: During and after reset, `wr_en`, `done` and `rec_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_flags | input | 8 | Command flags; bit 7 set means stop, clear means start |
| mem_depth | input | AW+1 | Memory depth in samples, 1..2^AW, latched at start |
| stream_mode | input | 1 | Selects the streaming limit for the window, latched at start |
| sample_count | input | CW | Requested total in 16-sample units, latched at start |
| pre_trig_req | input | CW+4 | Requested pre-trigger samples, latched at start |
| sample_valid | input | 1 | A sample is present this cycle |
| trig_hit | input | 1 | Trigger condition on the present sample |
| wr_en | output | 1 | Memory write enable |
| wr_addr | output | AW | Memory write address |
| done | output | 1 | Capture complete |
| rec_valid | output | 1 | Trigger record strobe |
| rec_trig_pos | output | CW+4 | Sample index of the accepted trigger |
| rec_start_addr | output | AW | Readout start address |
| rec_remain | output | CW+4 | Samples from the trigger to the end of the capture |

## Verification
The block's results are due at different times:
- `wr_en` and `wr_addr` are combinational on the present sample, so they are due in the same cycle as the sample.
- The record registers appear one edge after the accepting sample.
- `done` rises one edge after the final write.
- A stop blocks the write at once and clears state at the next edge.

The bench drives inputs at the falling edge and logs writes and records at the rising edge. It reads `done` and the write outputs at the falling edge that follows. The loop that feeds samples polls `done` before each new sample, so no extra sample is offered before the check that writes stopped.

// File: rtl/cwc_pkg.sv
package cwc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_ARMED,
        ST_POST,
        ST_DONE
    } cap_state_e;

    localparam int STOP_BIT = 7;
endpackage

// File: rtl/cwc_window_calc.sv
module cwc_window_calc #(
    parameter int IW       = 20,
    parameter int AW       = 10,
    parameter int ATOM_LG  = 6,
    parameter int BUF_PCT  = 90,
    parameter int STRM_PCT = 10
) (
    input  logic [IW-1:0] req_pos,
    input  logic [AW:0]   mem_depth,
    input  logic          stream_mode,
    output logic [IW-1:0] win_len
);
    localparam logic [IW-1:0] ATOM = IW'(1) << ATOM_LG;

    logic [IW-1:0] pct;
    logic [IW-1:0] cap;
    logic [IW-1:0] floored;
    logic [IW-1:0] clamped;

    always_comb begin
        pct     = stream_mode ? IW'(STRM_PCT) : IW'(BUF_PCT);
        cap     = (IW'(mem_depth) * pct) / IW'(100);
        floored = (req_pos < ATOM) ? ATOM : req_pos;
        clamped = (floored > cap) ? cap : floored;
        win_len = clamped & ~(ATOM - IW'(1));
    end
endmodule

// File: rtl/cwc_wrap_ctr.sv
module cwc_wrap_ctr #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic [AW:0]   limit,
    output logic [AW-1:0] cnt
);
    logic at_end;

    assign at_end = ({1'b0, cnt} == (limit - 1'b1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= at_end ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cwc_up_ctr.sv
module cwc_up_ctr #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/capture_window_ctrl.sv
module capture_window_ctrl
    import cwc_pkg::*;
#(
    parameter int AW       = 10,
    parameter int CW       = 16,
    parameter int ATOM_LG  = 6,
    parameter int BUF_PCT  = 90,
    parameter int STRM_PCT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_flags,
    input  logic [AW:0]      mem_depth,
    input  logic             stream_mode,
    input  logic [CW-1:0]    sample_count,
    input  logic [CW+3:0]    pre_trig_req,
    input  logic             sample_valid,
    input  logic             trig_hit,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic             done,
    output logic             rec_valid,
    output logic [CW+3:0]    rec_trig_pos,
    output logic [AW-1:0]    rec_start_addr,
    output logic [CW+3:0]    rec_remain
);
    localparam int IW = CW + 4;
    localparam logic [IW-1:0] ATOM = IW'(1) << ATOM_LG;

    cap_state_e st, st_nx;

    logic          abort_cmd, go_cmd, capturing, accept, post_last;
    logic          cmd_unused;
    logic [IW-1:0] win_calc, win_q, total_now, post_len_now, post_len_q;
    logic [AW:0]   depth_q;
    logic [IW-1:0] idx, post_cnt;
    logic [AW-1:0] start_now;

    assign cmd_unused = ^cmd_flags[STOP_BIT-1:0];

    cwc_window_calc #(
        .IW(IW), .AW(AW), .ATOM_LG(ATOM_LG),
        .BUF_PCT(BUF_PCT), .STRM_PCT(STRM_PCT)
    ) i_calc (
        .req_pos    (pre_trig_req),
        .mem_depth  (mem_depth),
        .stream_mode(stream_mode),
        .win_len    (win_calc)
    );

    cwc_wrap_ctr #(.AW(AW)) i_addr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (go_cmd),
        .step (wr_en),
        .limit(depth_q),
        .cnt  (wr_addr)
    );

    cwc_up_ctr #(.W(IW)) i_index (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (go_cmd),
        .step (wr_en),
        .cnt  (idx)
    );

    cwc_up_ctr #(.W(IW)) i_post (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (go_cmd),
        .step (wr_en && (accept || st == ST_POST)),
        .cnt  (post_cnt)
    );

    // Command decode and derived values
    always_comb begin
        abort_cmd    = cmd_valid && cmd_flags[STOP_BIT];
        go_cmd       = cmd_valid && !cmd_flags[STOP_BIT]
                       && (st == ST_IDLE || st == ST_DONE);
        total_now    = {sample_count, 4'b0000};
        post_len_now = (total_now > win_calc) ? (total_now - win_calc) : IW'(1);
        post_last    = ((post_cnt + IW'(1)) == post_len_q);
        if (wr_addr >= win_q[AW-1:0]) begin
            start_now = wr_addr - win_q[AW-1:0];
        end else begin
            start_now = wr_addr - win_q[AW-1:0] + depth_q[AW-1:0];
        end
    end

    // Outputs
    always_comb begin
        capturing = (st == ST_FILL) || (st == ST_ARMED) || (st == ST_POST);
        wr_en     = sample_valid && capturing && !abort_cmd;
        accept    = wr_en && trig_hit && (st == ST_ARMED);
        done      = (st == ST_DONE);
    end

    // Next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (go_cmd) st_nx = ST_FILL;
            end
            ST_FILL: begin
                if (abort_cmd) begin
                    st_nx = ST_IDLE;
                end else if (wr_en && (idx + IW'(1)) == win_q) begin
                    st_nx = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (abort_cmd) begin
                    st_nx = ST_IDLE;
                end else if (accept) begin
                    st_nx = post_last ? ST_DONE : ST_POST;
                end
            end
            ST_POST: begin
                if (abort_cmd) begin
                    st_nx = ST_IDLE;
                end else if (wr_en && post_last) begin
                    st_nx = ST_DONE;
                end
            end
            ST_DONE: begin
                if (abort_cmd) begin
                    st_nx = ST_IDLE;
                end else if (go_cmd) begin
                    st_nx = ST_FILL;
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Configuration latch and trigger record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q          <= '0;
            post_len_q     <= '0;
            depth_q        <= '0;
            rec_valid      <= 1'b0;
            rec_trig_pos   <= '0;
            rec_start_addr <= '0;
            rec_remain     <= '0;
        end else begin
            rec_valid <= accept;
            if (go_cmd) begin
                win_q          <= win_calc;
                post_len_q     <= post_len_now;
                depth_q        <= mem_depth;
                rec_trig_pos   <= '0;
                rec_start_addr <= '0;
                rec_remain     <= '0;
            end else if (accept) begin
                rec_trig_pos   <= idx;
                rec_start_addr <= start_now;
                rec_remain     <= post_len_q;
            end
        end
    end

    AST_WIN_QUANT: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |-> (win_q[ATOM_LG-1:0] == '0 && win_q >= ATOM)); // R1
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ({1'b0, wr_addr} < depth_q)); // R4
    AST_NO_WRITE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_en); // R3
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_flags[STOP_BIT]) |=> (!done && !rec_valid)); // R7
    AST_REC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |=> !rec_valid); // R6
    AST_TRIG_AFTER_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> (rec_trig_pos >= win_q)); // R5
endmodule

// File: tb/test_capture_window_ctrl.sv
`timescale 1ns/1ps
module test_capture_window_ctrl;
    localparam int AW = 10;
    localparam int CW = 16;
    localparam int NV = 7;
    // depth, req, units, stream, hit, pos, start, remain, writes, last_addr
    localparam int VEC [NV][10] = '{
        '{1024,  100, 20, 0,  200,  64, 136, 256,  456, 455},
        '{1024,   10, 10, 0,   64,  64,   0,  96,  160, 159},
        '{1024, 2000, 60, 0, 1000, 896, 104,  64, 1064,  39},
        '{1024,  500, 16, 1,  150,  64,  86, 192,  342, 341},
        '{1024,  130, 40, 0,  900, 128, 772, 512, 1412, 387},
        '{1024,   64,  8, 1,   64,  64,   0,  64,  128, 127},
        '{ 600, 1000, 36, 0,  550, 512,  38,  64,  614,  13}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic [7:0]      cmd_flags = 8'h00;
    logic [AW:0]     mem_depth = 11'd1024;
    logic            stream_mode = 1'b0;
    logic [CW-1:0]   sample_count = '0;
    logic [CW+3:0]   pre_trig_req = '0;
    logic            sample_valid = 1'b0;
    logic            trig_hit = 1'b0;
    logic            wr_en;
    logic [AW-1:0]   wr_addr;
    logic            done;
    logic            rec_valid;
    logic [CW+3:0]   rec_trig_pos;
    logic [AW-1:0]   rec_start_addr;
    logic [CW+3:0]   rec_remain;

    int n_run = 0;
    int n_fail = 0;
    int tb_idx = 0;
    int writes_total = 0;
    int rec_total = 0;
    int last_addr = 0;
    int got_tp = 0, got_start = 0, got_rem = 0;
    int mem [0:(1<<AW)-1];

    always #2 clk = ~clk;

    capture_window_ctrl #(.AW(AW), .CW(CW)) i_capture_window_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_flags(cmd_flags),
        .mem_depth(mem_depth), .stream_mode(stream_mode),
        .sample_count(sample_count), .pre_trig_req(pre_trig_req),
        .sample_valid(sample_valid), .trig_hit(trig_hit),
        .wr_en(wr_en), .wr_addr(wr_addr), .done(done), .rec_valid(rec_valid),
        .rec_trig_pos(rec_trig_pos), .rec_start_addr(rec_start_addr),
        .rec_remain(rec_remain)
    );

    // Behavioural sample memory and record logger
    always @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= tb_idx;
            writes_total <= writes_total + 1;
            last_addr    <= int'(wr_addr);
        end
        if (rec_valid) begin
            rec_total <= rec_total + 1;
            got_tp    <= int'(rec_trig_pos);
            got_start <= int'(rec_start_addr);
            got_rem   <= int'(rec_remain);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [7:0] f);
        @(negedge clk);
        cmd_flags = f;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic run_vec(input int v);
        int base_w, base_r, i, cyc, hit;
        mem_depth    = (AW+1)'(VEC[v][0]);
        pre_trig_req = (CW+4)'(VEC[v][1]);
        sample_count = CW'(VEC[v][2]);
        stream_mode  = (VEC[v][3] != 0);
        hit          = VEC[v][4];
        send_cmd(8'h00);
        base_w = writes_total;
        base_r = rec_total;
        i = 0;
        cyc = 0;
        while (cyc < 6000) begin
            @(negedge clk);
            if (done) break;
            if (cyc % 5 == 3) begin
                sample_valid = 1'b0;
                trig_hit     = 1'b0;
            end else begin
                sample_valid = 1'b1;
                tb_idx       = i;
                trig_hit     = (i == 5) || (i == hit);  // early hit must be ignored (R5)
                i++;
            end
            cyc++;
        end
        sample_valid = 1'b0;
        trig_hit     = 1'b0;
        chk("R3 done reached", int'(done), 1);
        chk("R6 trigger index", got_tp, hit);
        chk("R1 R2 R6 start address", got_start, VEC[v][6]);
        chk("R6 remaining count", got_rem, VEC[v][7]);
        chk("R5 R6 one record", rec_total - base_r, 1);
        chk("R3 total writes", writes_total - base_w, VEC[v][8]);
        chk("R4 last address", last_addr, VEC[v][9]);
        chk("R4 window head data", mem[VEC[v][6]], hit - VEC[v][5]);
        base_w = writes_total;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            sample_valid = 1'b1;
        end
        @(negedge clk);
        sample_valid = 1'b0;
        @(negedge clk);
        chk("R3 no write after done", writes_total - base_w, 0);
    endtask

    initial begin
        int base_w, base_r;
        sample_valid = 1'b1;
        cmd_valid    = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 wr_en in reset", int'(wr_en), 0);
        chk("R9 done in reset", int'(done), 0);
        chk("R9 rec_valid in reset", int'(rec_valid), 0);
        cmd_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 wr_en after reset", int'(wr_en), 0);
        sample_valid = 1'b0;

        for (int v = 0; v < NV; v++) run_vec(v);

        // R8: restart from done
        chk("R3 done held", int'(done), 1);
        mem_depth    = 11'd1024;
        pre_trig_req = 20'd64;
        sample_count = 16'd20;
        stream_mode  = 1'b0;
        send_cmd(8'h00);
        chk("R8 done cleared by start", int'(done), 0);
        chk("R8 address restarts", int'(wr_addr), 0);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            sample_valid = 1'b1;
        end
        // R8: start during capture ignored
        @(negedge clk);
        sample_valid = 1'b1;
        cmd_flags    = 8'h00;
        cmd_valid    = 1'b1;
        #1;
        chk("R8 address before busy start", int'(wr_addr), 10);
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
        chk("R8 busy start ignored", int'(wr_addr), 11);

        // R7: stop aborts
        @(negedge clk);
        base_w       = writes_total;
        base_r       = rec_total;
        cmd_flags    = 8'h80;
        cmd_valid    = 1'b1;
        sample_valid = 1'b1;
        trig_hit     = 1'b1;
        #1;
        chk("R7 write blocked on stop", int'(wr_en), 0);
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
        chk("R7 no write after stop", int'(wr_en), 0);
        chk("R7 done low after stop", int'(done), 0);
        repeat (100) @(negedge clk);
        sample_valid = 1'b0;
        trig_hit     = 1'b0;
        @(negedge clk);
        chk("R7 write count frozen", writes_total - base_w, 0);
        chk("R7 no record", rec_total - base_r, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule